// File: doc/BRIEF.md
# Eight-bit processor bus cycle sequencer

This block generates the external bus machine cycles for a small 8-bit processor core that supports three instructions: direct accumulator load, direct accumulator store and write to an output port. It fetches the opcode and steps through the machine cycles that the opcode needs. Each cycle is divided into T-states. The block inserts an internal decode T-state after every opcode fetch and stretches any bus cycle with wait states while the ready input is low. It drives the address, the address latch enable, the status lines, the memory/IO select and the active-low read and write strobes.

Byte fetches from memory arrive on the data input. The accumulator value enters on its own input and is driven out during write cycles. A loaded byte is returned to the accumulator through a one-cycle write pulse. After each instruction the block raises a one-cycle completion pulse together with the total number of T-states the instruction used, wait states included. An opcode outside the subset takes four T-states and does nothing else.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held, the block sits in the first T-state of an opcode fetch at address RESET_PC (default 0000h). In that state ale=1, rd_n=1, wr_n=1, instr_done=0 and acc_we=0.
- R2: Each bus machine cycle runs T1, T2, zero or more wait states, then T3. ale is 1 only in T1. rd_n is low in T2, in the wait states and in T3 of read cycles, and wr_n is low in the same states of write cycles. The two strobes are never low together.
- R3: An opcode fetch is followed by exactly one decode T-state with ale=0, rd_n=1 and wr_n=1. The next T-state starts a new bus cycle.
- R4: The status lines {io_m,s1,s0} are 3'b011 for an opcode fetch, 3'b010 for an operand or data memory read, 3'b001 for a memory write and 3'b101 for a port write. They are held for the whole machine cycle.
- R5: Opcode 32h (store) runs an opcode fetch, a read of the low address byte, a read of the high address byte, then a memory write of acc_in to {high,low}. With no wait states this takes 13 T-states.
- R6: Opcode 3Ah (load) runs the same first three cycles as store, then a memory read at {high,low}. It takes 13 T-states. In the clock after that read's T3, acc_we=1 and acc_wdata carries the byte read.
- R7: Opcode D3h (output) runs an opcode fetch, a read of the port byte, then a port write with the port number on both address bytes and acc_in on dout. It takes 10 T-states.
- R8: Address operands are read low byte first. The program counter (the address of every fetch cycle) rises by exactly one after each opcode or operand byte fetched.
- R9: ready is sampled in T2 and in each wait state. A low level there gives one more wait state, which holds the address, the strobe and the status and adds one to the instruction's T-state count.
- R10: Any other opcode takes 4 T-states (fetch plus decode), advances the program counter by one, and is followed directly by the next opcode fetch.
- R11: In the clock after an instruction's last T-state, instr_done is 1 for one cycle and instr_tstates holds the instruction's T-state count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | input | 1 | High to end a bus cycle; low adds wait states |
| din | input | 8 | Byte read from memory |
| acc_in | input | 8 | Current accumulator value |
| addr | output | 16 | Bus address, valid from T1 to T3 |
| dout | output | 8 | Write data (acc_in in write cycles, else 0) |
| ale | output | 1 | Address latch enable, high in T1 |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| io_m | output | 1 | High for port cycles, low for memory cycles |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| acc_we | output | 1 | Accumulator load pulse |
| acc_wdata | output | 8 | Byte for the accumulator |
| instr_done | output | 1 | One-cycle instruction-complete pulse |
| instr_tstates | output | CNT_W | T-state count of the finished instruction |

## Verification
The bench walks each instruction through its expected T-states and compares all outputs on every clock against a behavioural model. It adds wait states in different cycles of the same instruction and checks that each one adds exactly one to the count. A design that sampled ready in T3, or that counted only nominal states, would report 13 where 17 is due. Unsupported opcodes (00h, FFh) sit between real ones: a sequencer that dropped the decode state, or that failed to advance past such an opcode, would misalign every later fetch address. A load that is followed by a store checks that the byte read returns through the accumulator pulse, and a port write checks that the port byte appears on both address halves.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // Machine cycle kinds
    typedef enum logic [2:0] {
        MC_OPF = 3'd0,   // opcode fetch
        MC_ALO = 3'd1,   // low address byte fetch
        MC_AHI = 3'd2,   // high address byte fetch
        MC_PRT = 3'd3,   // port number fetch
        MC_MRD = 3'd4,   // data memory read
        MC_MWR = 3'd5,   // data memory write
        MC_IOW = 3'd6    // port write
    } mcyc_e;

    // T-states within a machine cycle
    typedef enum logic [2:0] {
        TS_1 = 3'd0,
        TS_2 = 3'd1,
        TS_W = 3'd2,
        TS_3 = 3'd3,
        TS_4 = 3'd4
    } tst_e;

    localparam logic [7:0] OPC_LOAD  = 8'h3A;
    localparam logic [7:0] OPC_STORE = 8'h32;
    localparam logic [7:0] OPC_PORT  = 8'hD3;

endpackage

// File: rtl/bcs_cycle_plan.sv
module bcs_cycle_plan
    import bcs_pkg::*;
(
    input  mcyc_e      mc,
    input  logic [7:0] opc,
    output mcyc_e      nxt_mc,
    output logic       last,
    output logic       rd_cyc,
    output logic       wr_cyc,
    output logic       fetch,
    output logic       io_m,
    output logic       s1,
    output logic       s0
);

    logic is_load;
    logic is_store;
    logic is_port;

    always_comb begin
        is_load  = (opc == OPC_LOAD);
        is_store = (opc == OPC_STORE);
        is_port  = (opc == OPC_PORT);
    end

    // successor cycle and end-of-instruction flag
    always_comb begin
        nxt_mc = MC_OPF;
        last   = 1'b0;
        case (mc)
            MC_OPF: begin
                if (is_load || is_store) nxt_mc = MC_ALO;
                else if (is_port)        nxt_mc = MC_PRT;
                else                     last   = 1'b1;
            end
            MC_ALO: nxt_mc = MC_AHI;
            MC_AHI: nxt_mc = is_load ? MC_MRD : MC_MWR;
            MC_PRT: nxt_mc = MC_IOW;
            default: last = 1'b1;
        endcase
    end

    // bus direction, fetch flag and status encoding
    always_comb begin
        rd_cyc = 1'b0;
        wr_cyc = 1'b0;
        fetch  = 1'b0;
        io_m   = 1'b0;
        s1     = 1'b0;
        s0     = 1'b0;
        case (mc)
            MC_OPF: begin
                rd_cyc = 1'b1; fetch = 1'b1; s1 = 1'b1; s0 = 1'b1;
            end
            MC_ALO, MC_AHI, MC_PRT: begin
                rd_cyc = 1'b1; fetch = 1'b1; s1 = 1'b1;
            end
            MC_MRD: begin
                rd_cyc = 1'b1; s1 = 1'b1;
            end
            MC_MWR: begin
                wr_cyc = 1'b1; s0 = 1'b1;
            end
            MC_IOW: begin
                wr_cyc = 1'b1; s0 = 1'b1; io_m = 1'b1;
            end
            default: begin
                rd_cyc = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bcs_tcount.sv
module bcs_tcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_d;
    logic [CNT_W-1:0] count_q;

    // count_q is the index of the current T-state, starting at 1
    always_comb begin
        if (restart)             count_d = ONE;
        else if (count_q != TOP) count_d = count_q + ONE;
        else                     count_d = count_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= ONE;
        else        count_q <= count_d;
    end

    assign count = count_q;

    // R11: the index never wraps to zero
    a_r11_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        count_q != '0);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000,
    parameter int          CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready,
    input  logic [7:0]       din,
    input  logic [7:0]       acc_in,
    output logic [15:0]      addr,
    output logic [7:0]       dout,
    output logic             ale,
    output logic             s1,
    output logic             s0,
    output logic             io_m,
    output logic             rd_n,
    output logic             wr_n,
    output logic             acc_we,
    output logic [7:0]       acc_wdata,
    output logic             instr_done,
    output logic [CNT_W-1:0] instr_tstates
);

    typedef struct packed {
        mcyc_e            mc;
        tst_e             ts;
        logic [15:0]      pc;
        logic [7:0]       opc;
        logic [7:0]       lo;
        logic [7:0]       hi;
        logic             done;
        logic [CNT_W-1:0] tcnt;
        logic             accwe;
        logic [7:0]       accd;
    } seq_t;

    seq_t state_d;
    seq_t state_q;

    mcyc_e            nxt_mc;
    logic             last;
    logic             rd_cyc;
    logic             wr_cyc;
    logic             fetch;
    logic             restart;
    logic             strobe;
    logic [CNT_W-1:0] tidx;

    bcs_cycle_plan u_plan (
        .mc     (state_q.mc),
        .opc    (state_q.opc),
        .nxt_mc (nxt_mc),
        .last   (last),
        .rd_cyc (rd_cyc),
        .wr_cyc (wr_cyc),
        .fetch  (fetch),
        .io_m   (io_m),
        .s1     (s1),
        .s0     (s0)
    );

    bcs_tcount #(.CNT_W(CNT_W)) u_tcount (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .count   (tidx)
    );

    assign strobe = (state_q.ts == TS_2) || (state_q.ts == TS_W) || (state_q.ts == TS_3);

    always_comb begin
        state_d       = state_q;
        state_d.done  = 1'b0;
        state_d.accwe = 1'b0;
        restart       = 1'b0;
        case (state_q.ts)
            TS_1: state_d.ts = TS_2;
            TS_2, TS_W: state_d.ts = ready ? TS_3 : TS_W;
            TS_3: begin
                case (state_q.mc)
                    MC_OPF:         state_d.opc = din;
                    MC_ALO, MC_PRT: state_d.lo  = din;
                    MC_AHI:         state_d.hi  = din;
                    MC_MRD: begin
                        state_d.accwe = 1'b1;
                        state_d.accd  = din;
                    end
                    default: state_d.accd = state_q.accd;
                endcase
                if (fetch) state_d.pc = state_q.pc + 16'd1;
                if (state_q.mc == MC_OPF) begin
                    state_d.ts = TS_4;
                end else begin
                    state_d.ts = TS_1;
                    if (last) begin
                        state_d.mc   = MC_OPF;
                        state_d.done = 1'b1;
                        state_d.tcnt = tidx;
                        restart      = 1'b1;
                    end else begin
                        state_d.mc = nxt_mc;
                    end
                end
            end
            TS_4: begin
                state_d.ts = TS_1;
                if (last) begin
                    state_d.mc   = MC_OPF;
                    state_d.done = 1'b1;
                    state_d.tcnt = tidx;
                    restart      = 1'b1;
                end else begin
                    state_d.mc = nxt_mc;
                end
            end
            default: state_d.ts = TS_1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.mc    <= MC_OPF;
            state_q.ts    <= TS_1;
            state_q.pc    <= RESET_PC;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (state_q.mc)
            MC_MRD, MC_MWR: addr = {state_q.hi, state_q.lo};
            MC_IOW:         addr = {state_q.lo, state_q.lo};
            default:        addr = state_q.pc;
        endcase
    end

    assign ale           = (state_q.ts == TS_1);
    assign rd_n          = !(strobe && rd_cyc);
    assign wr_n          = !(strobe && wr_cyc);
    assign dout          = wr_cyc ? acc_in : 8'h00;
    assign acc_we        = state_q.accwe;
    assign acc_wdata     = state_q.accd;
    assign instr_done    = state_q.done;
    assign instr_tstates = state_q.tcnt;

    // R2: T1 is always followed by a strobed T2
    a_r2_ale_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && (!rd_n || !wr_n)));

    // R3: the decode state is quiet and comes right after a read strobe
    a_r3_decode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ts == TS_4) |-> (!ale && rd_n && wr_n && !$past(rd_n)));

    // R9: a low ready during a pre-T3 strobe state holds strobe and address
    a_r9_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_n || !wr_n) && !ready && (state_q.ts != TS_3))
        |=> ((!rd_n || !wr_n) && $stable(addr)));

    // R8: the program counter only ever steps by one
    a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.pc != $past(state_q.pc)) |-> (state_q.pc == $past(state_q.pc) + 16'd1));

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done);

endmodule

// File: tb/bus_cycle_seq_tb_top.sv
module bus_cycle_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready = 1'b1;
    logic [7:0]  din;
    logic [7:0]  acc_in = 8'h3C;
    logic [15:0] addr;
    logic [7:0]  dout;
    logic        ale, s1, s0, io_m, rd_n, wr_n, acc_we, instr_done;
    logic [7:0]  acc_wdata;
    logic [7:0]  instr_tstates;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] prog [0:63];

    // behavioural model state
    int          ref_pc = 0;
    int          tcount = 0;
    bit          pend_done = 1'b0;
    int          pend_cnt = 0;
    string       pend_tag = "R11";
    bit          pend_we = 1'b0;
    logic [7:0]  pend_val = 8'h00;

    function automatic logic [7:0] memfn(input logic [15:0] a);
        if (a < 16'd64) return prog[a[5:0]];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign din = memfn(addr);

    always #5 clk = ~clk;

    bus_cycle_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ready(ready), .din(din), .acc_in(acc_in),
        .addr(addr), .dout(dout), .ale(ale), .s1(s1), .s0(s0), .io_m(io_m),
        .rd_n(rd_n), .wr_n(wr_n), .acc_we(acc_we), .acc_wdata(acc_wdata),
        .instr_done(instr_done), .instr_tstates(instr_tstates)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // completion and accumulator pulse, due only in a T1
    task automatic chk_pending(input bit in_t1);
        bit ed = in_t1 && pend_done;
        bit ew = in_t1 && pend_we;
        chk(instr_done == ed, "R11", "instr_done", instr_done, ed);
        if (ed) chk(instr_tstates == pend_cnt[7:0], pend_tag, "tstates", instr_tstates, pend_cnt);
        chk(acc_we == ew, "R6", "acc_we", acc_we, ew);
        if (ew) chk(acc_wdata == pend_val, "R6", "acc_wdata", acc_wdata, pend_val);
        if (in_t1) begin
            pend_done = 1'b0;
            pend_we   = 1'b0;
        end
    endtask

    task automatic look(input bit e_ale, input bit e_rd, input bit e_wr,
                        input logic [2:0] e_st, input bit c_addr,
                        input logic [15:0] e_addr, input string atag,
                        input bit c_dout, input string dtag);
        chk(ale == e_ale, "R2", "ale", ale, e_ale);
        chk(rd_n == !e_rd, "R2", "rd_n", rd_n, !e_rd);
        chk(wr_n == !e_wr, "R2", "wr_n", wr_n, !e_wr);
        chk({io_m, s1, s0} == e_st, "R4", "status", {io_m, s1, s0}, e_st);
        if (c_addr) chk(addr == e_addr, atag, "addr", addr, e_addr);
        if (c_dout) chk(dout == acc_in, dtag, "dout", dout, acc_in);
        chk_pending(e_ale);
        tcount++;
        @(negedge clk);
    endtask

    // kind: 0 opcode fetch, 1 memory read, 2 memory write, 3 port write
    task automatic bus_cyc(input int kind, input logic [15:0] a, input int waits,
                           input string tag);
        logic [2:0] st;
        bit r = (kind <= 1);
        bit w = !r;
        case (kind)
            0: st = 3'b011;
            1: st = 3'b010;
            2: st = 3'b001;
            default: st = 3'b101;
        endcase
        look(1'b1, 1'b0, 1'b0, st, 1'b1, a, tag, 1'b0, tag);
        ready = (waits == 0);
        look(1'b0, r, w, st, 1'b1, a, tag, w, tag);
        for (int i = 0; i < waits; i++) begin
            ready = (i == waits - 1);
            look(1'b0, r, w, st, 1'b1, a, "R9", w, tag);
        end
        ready = 1'b1;
        look(1'b0, r, w, st, 1'b1, a, tag, w, tag);
        if (kind == 0) look(1'b0, 1'b0, 1'b0, 3'b011, 1'b0, 16'h0, "R3", 1'b0, "R3");
    endtask

    task automatic run_instr(input int w0, input int w1, input int w2, input int w3);
        logic [7:0] op, lo, hi;
        string tg;
        tcount = 0;
        op = memfn(ref_pc[15:0]);
        case (op)
            8'h32:   tg = "R5";
            8'h3A:   tg = "R6";
            8'hD3:   tg = "R7";
            default: tg = "R10";
        endcase
        bus_cyc(0, ref_pc[15:0], w0, "R8");
        ref_pc++;
        if (op == 8'h32 || op == 8'h3A) begin
            lo = memfn(ref_pc[15:0]);
            bus_cyc(1, ref_pc[15:0], w1, "R8");
            ref_pc++;
            hi = memfn(ref_pc[15:0]);
            bus_cyc(1, ref_pc[15:0], w2, "R8");
            ref_pc++;
            if (op == 8'h3A) begin
                bus_cyc(1, {hi, lo}, w3, tg);
                pend_we  = 1'b1;
                pend_val = memfn({hi, lo});
            end else begin
                bus_cyc(2, {hi, lo}, w3, tg);
            end
        end else if (op == 8'hD3) begin
            lo = memfn(ref_pc[15:0]);
            bus_cyc(1, ref_pc[15:0], w1, "R8");
            ref_pc++;
            bus_cyc(3, {lo, lo}, w2, tg);
        end
        pend_done = 1'b1;
        pend_cnt  = tcount;
        pend_tag  = (w0 + w1 + w2 + w3 != 0) ? "R9" : tg;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) prog[i] = 8'h00;
        prog[0]  = 8'h32; prog[1]  = 8'h00; prog[2]  = 8'h42;
        prog[3]  = 8'h3A; prog[4]  = 8'h34; prog[5]  = 8'h12;
        prog[6]  = 8'hD3; prog[7]  = 8'h84;
        prog[8]  = 8'h00;
        prog[9]  = 8'h32; prog[10] = 8'h10; prog[11] = 8'h20;
        prog[12] = 8'h3A; prog[13] = 8'h55; prog[14] = 8'h66;
        prog[15] = 8'hD3; prog[16] = 8'h07;
        prog[17] = 8'hFF;
        prog[18] = 8'h3A; prog[19] = 8'h00; prog[20] = 8'h43;
        prog[21] = 8'h32; prog[22] = 8'h01; prog[23] = 8'h43;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(ale == 1'b1, "R1", "ale", ale, 1);
        chk(addr == 16'h0000, "R1", "addr", addr, 0);
        chk(rd_n == 1'b1 && wr_n == 1'b1, "R1", "strobes", {rd_n, wr_n}, 3);
        chk(instr_done == 1'b0 && acc_we == 1'b0, "R1", "pulses", {instr_done, acc_we}, 0);
        chk({io_m, s1, s0} == 3'b011, "R1", "status", {io_m, s1, s0}, 3);
        rst_n = 1'b1;

        run_instr(0, 0, 0, 0);              // store, 13
        run_instr(0, 0, 0, 0);              // load, 13
        acc_in = pend_val;                  // model the accumulator update
        run_instr(0, 0, 0, 0);              // output, 10
        run_instr(0, 0, 0, 0);              // unsupported, 4
        run_instr(1, 0, 2, 1);              // store, 17
        run_instr(0, 3, 0, 2);              // load, 18
        acc_in = pend_val;
        run_instr(2, 1, 3, 0);              // output, 16
        run_instr(1, 0, 0, 0);              // unsupported, 5
        run_instr(0, 0, 0, 0);              // load, 13
        acc_in = pend_val;
        run_instr(0, 0, 0, 0);              // store of the loaded value, 13
        chk_pending(1'b1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule